// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Command and Data Control

This block sits between a synchronous command bus and an internal word array. On every rising clock edge where the active-low clock enable is low, it samples three chip selects, an advance/load strobe, a write strobe, five active-low byte enables, an address and a data word. A load edge with all three selects active opens an access. Read data then comes straight out of the array in the cycle that follows that edge, with no output register on the way (flow-through). Write data follows its command one cycle later (late write). Because of this, reads and writes can alternate on consecutive edges with no idle cycle between them.

After a load, edges with advance/load high step a 2-bit burst counter over the two low address bits. A static input selects linear or interleaved order. The operation chosen at load time is kept for the whole burst. A high clock enable freezes the block completely. The bus direction is modelled as separate data-in, data-out and output-enable ports. The output enable is never raised in a write data cycle or in a deselected cycle. An asynchronous output-enable input gates read data.

Three command states drive the control: `ST_DESEL` (no access in progress), `ST_READ` (read data cycle) and `ST_WRITE` (write data cycle). The named transitions are:
- load-read and load-write move from any state into `ST_READ` or `ST_WRITE`.
- load-deselect moves from any state into `ST_DESEL`.
- advance keeps `ST_READ` or `ST_WRITE` and steps the burst counter.
- idle-advance keeps `ST_DESEL` without stepping the counter.
- stall keeps any state with everything frozen.

Top module: `fts_ctrl`

## Requirements
- R1: A new access is opened only on an edge with clk_en_n=0, load_n=0, sel_a_n=0, sel_b=1 and sel_c_n=0. Any other select combination on a load edge deselects: no data is driven and no write takes place.
- R2: On an edge with clk_en_n=1, nothing changes: the state, the burst address, the pending write and the data-out stay as they are, and din is not sampled at that edge.
- R3: After a read load edge, dout carries the word at the loaded address, and dout_en is 1 until the next enabled edge, but only while oe_n=0. oe_n acts asynchronously: with oe_n=1 the cycle is a dummy read with dout_en=0.
- R4: After a write load or write advance edge, the next enabled edge stores din, and dout_en stays 0 during that data cycle whatever the value of oe_n.
- R5: byte_en_n[i]=0 lets din[8i+7:8i] into the word; byte_en_n[i]=1 keeps the old byte. The byte enables are sampled on the command edge. With all five enables high, the write is a dummy write that changes nothing.
- R6: On an edge with load_n=0 not asserted (load_n=1 and clk_en_n=0) during a burst, the selects, wr_n and addr are ignored. The operation latched at load continues, and the address bits above bit 1 do not change.
- R7: With burst_ilv=0, the low two address bits of beat k are (start + k) mod 4, wrapping past the fourth beat.
- R8: With burst_ilv=1, the low two address bits of beat k are start XOR (k mod 4).
- R9: In a deselected cycle dout_en is 0. An edge with load_n=1 after a deselect keeps the block deselected even with all selects active.
- R10: During and right after reset the block is deselected: dout_en=0 and dout=0.
- R11: A read returns the most recent completed write to its address. This includes a write whose data edge is the read's own load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock qualifier; high stalls |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low loads a new command, high advances the burst |
| wr_n | input | 1 | Low selects write on a load edge |
| byte_en_n | input | LANES | Active-low byte lane write enables |
| addr | input | AW | Word address |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W | Write data, sampled one enabled edge after its command |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable for the data bus |

## Verification
Every address is first written in one unbroken write stream and then read back in one unbroken read stream. Each address carries a distinct arithmetic pattern, so any addressing or late-write slip shows up. Reads and writes are then interleaved on the same address, which separates a correct same-edge write from stale data.

All 32 byte-enable values are applied over zeroed words, which exposes any swapped or stuck lane. Write and read bursts from each of the four start offsets in both orders, with a fifth wrapping beat, tell linear from interleaved sequencing. Stalls, deselects, partial selects and oe_n toggled inside a read cycle check the freeze, the ignore and the output-gating rules.

// File: rtl/fts_pkg.sv
package fts_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } fts_state_e;

    // Low two address bits of burst beat k from the start offset.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       ilv);
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/fts_burst_addr.sv
module fts_burst_addr
    import fts_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          ilv,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] eff_addr
);

    logic [AW-1:0] base_q;
    logic [1:0]    beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= 2'd0;
        end else if (load) begin
            base_q <= addr_in;
            beat_q <= 2'd0;
        end else if (adv) begin
            beat_q <= beat_q + 2'd1;
        end
    end

    assign eff_addr = {base_q[AW-1:2], burst_low(base_q[1:0], beat_q, ilv)};

endmodule

// File: rtl/fts_store.sv
module fts_store #(
    parameter int AW     = 8,
    parameter int LANES  = 5,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES-1:0]        wmask_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] old_word;
    logic [DW-1:0] merged;

    assign old_word = mem[waddr];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = wmask_n[g] ? old_word[g*LANE_W +: LANE_W]
                                                       : wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[waddr] <= merged;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fts_cmd_fsm.sv
module fts_cmd_fsm
    import fts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en_n,
    input  logic       load_n,
    input  logic       sel_ok,
    input  logic       wr_n,
    output fts_state_e state_q,
    output logic       load_o,
    output logic       adv_o,
    output logic       commit_o
);

    fts_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and strobes.
    always_comb begin
        state_d  = state_q;
        load_o   = 1'b0;
        adv_o    = 1'b0;
        commit_o = 1'b0;
        unique case (state_q)
            ST_DESEL: begin
                if (!clk_en_n && !load_n) begin
                    load_o  = sel_ok;
                    state_d = !sel_ok ? ST_DESEL : (wr_n ? ST_READ : ST_WRITE);
                end
            end
            ST_READ: begin
                if (!clk_en_n) begin
                    if (!load_n) begin
                        load_o  = sel_ok;
                        state_d = !sel_ok ? ST_DESEL : (wr_n ? ST_READ : ST_WRITE);
                    end else begin
                        adv_o = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                if (!clk_en_n) begin
                    commit_o = 1'b1;
                    if (!load_n) begin
                        load_o  = sel_ok;
                        state_d = !sel_ok ? ST_DESEL : (wr_n ? ST_READ : ST_WRITE);
                    end else begin
                        adv_o = 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_DESEL;
            end
        endcase
    end

endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
    import fts_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANES  = 5,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    load_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        byte_en_n,
    input  logic [AW-1:0]           addr,
    input  logic                    burst_ilv,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DW = LANES * LANE_W;

    logic            sel_ok;
    fts_state_e      cur_state;
    logic            load_s;
    logic            adv_s;
    logic            commit_s;
    logic [AW-1:0]   cur_addr;
    logic [LANES-1:0] mask_q;
    logic [DW-1:0]   rd_word;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    fts_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_n (clk_en_n),
        .load_n   (load_n),
        .sel_ok   (sel_ok),
        .wr_n     (wr_n),
        .state_q  (cur_state),
        .load_o   (load_s),
        .adv_o    (adv_s),
        .commit_o (commit_s)
    );

    fts_burst_addr #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_s),
        .adv      (adv_s),
        .ilv      (burst_ilv),
        .addr_in  (addr),
        .eff_addr (cur_addr)
    );

    // Byte enables travel with their command edge into the data cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (load_s || adv_s) begin
            mask_q <= byte_en_n;
        end
    end

    fts_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .wr_en   (commit_s),
        .waddr   (cur_addr),
        .wmask_n (mask_q),
        .wdata   (din),
        .raddr   (cur_addr),
        .rdata   (rd_word)
    );

    assign dout_en = (cur_state == ST_READ) && !oe_n;
    assign dout    = dout_en ? rd_word : '0;

endmodule

// File: rtl/fts_ctrl_chk.sv
module fts_ctrl_chk
    import fts_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          load_n,
    input logic          wr_n,
    input logic          burst_ilv,
    input logic          oe_n,
    input logic          dout_en,
    input fts_state_e    st,
    input logic [AW-1:0] eff_addr
);

    logic all_sel;
    assign all_sel = !sel_a_n && sel_b && !sel_c_n;

    p_rst_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> !dout_en);

    p_wr_data_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && all_sel && !wr_n) |=> !dout_en);

    p_desel_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && !all_sel) |=> !dout_en);

    p_idle_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && st == ST_DESEL) |=> st == ST_DESEL);

    p_rd_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && all_sel && wr_n) |=> (oe_n || dout_en));

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(st) && $stable(eff_addr)));

    p_adv_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n) |=> ($stable(st) && $stable(eff_addr[AW-1:2])));

    p_lin_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && !burst_ilv && st != ST_DESEL)
        |=> eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1);

    p_ilv_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && burst_ilv && st != ST_DESEL)
        |=> eff_addr[0] != $past(eff_addr[0]));

endmodule

bind fts_ctrl fts_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .load_n    (load_n),
    .wr_n      (wr_n),
    .burst_ilv (burst_ilv),
    .oe_n      (oe_n),
    .dout_en   (dout_en),
    .st        (cur_state),
    .eff_addr  (cur_addr)
);

// File: tb/tb_fts_ctrl.sv
module tb_fts_ctrl;

    localparam int CLK_P = 10;
    localparam int AW    = 8;
    localparam int DW    = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          load_n = 1'b0;
    logic          wr_n = 1'b1;
    logic [4:0]    byte_en_n = '1;
    logic [AW-1:0] addr = '0;
    logic          burst_ilv = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model of the array and of the pending write.
    logic [DW-1:0] mdl [1 << AW];
    bit            pw = 0, nw = 0;
    logic [AW-1:0] pa, na;
    logic [4:0]    pm, nm;

    fts_ctrl dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .load_n(load_n), .wr_n(wr_n), .byte_en_n(byte_en_n),
        .addr(addr), .burst_ilv(burst_ilv), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return {8'(a ^ s), 8'(~a), 8'(a + s), 8'(a * 3), 8'(s + 17)};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                           input logic [DW-1:0] d,
                                           input logic [4:0] m);
        logic [DW-1:0] r = old;
        for (int i = 0; i < 5; i++) if (!m[i]) r[i*8 +: 8] = d[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [7:0] ea(input logic [7:0] a, input int k, input bit ilv);
        logic [1:0] s = a[1:0];
        logic [1:0] kk = 2'(k);
        return {a[7:2], ilv ? (s ^ kk) : 2'(s + kk)};
    endfunction

    task automatic chk_b(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_v(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input logic [DW-1:0] d);
        din = d;
        @(posedge clk);
        if (!clk_en_n) begin
            if (pw) mdl[pa] = merge(mdl[pa], d, pm);
            pw = nw; pa = na; pm = nm;
        end
        @(negedge clk);
    endtask

    task automatic issue(input bit an, input bit b, input bit cn, input bit w,
                         input logic [7:0] a, input logic [4:0] be, input logic [DW-1:0] d);
        clk_en_n = 0; load_n = 0;
        sel_a_n = an; sel_b = b; sel_c_n = cn; wr_n = w;
        addr = a; byte_en_n = be;
        nw = (!an && b && !cn) && !w; na = a; nm = be;
        tick(d);
    endtask

    task automatic ld_wr(input logic [7:0] a, input logic [4:0] be, input logic [DW-1:0] d);
        issue(0, 1, 0, 0, a, be, d);
    endtask

    task automatic ld_rd(input logic [7:0] a, input logic [DW-1:0] d);
        issue(0, 1, 0, 1, a, 5'h1f, d);
    endtask

    task automatic desel(input logic [DW-1:0] d);
        issue(1, 1, 0, 1, 8'h00, 5'h1f, d);
    endtask

    // Advance with selects inactive and wr_n opposite to the latched op (R6).
    task automatic adv(input bit wr_op, input logic [7:0] eff, input logic [4:0] be,
                       input logic [DW-1:0] d);
        clk_en_n = 0; load_n = 1;
        sel_a_n = 1; sel_b = 0; sel_c_n = 1; wr_n = wr_op;
        addr = ~eff; byte_en_n = be;
        nw = wr_op; na = eff; nm = be;
        tick(d);
    endtask

    // Stall with a write load pattern on the pins; all of it must be ignored.
    task automatic stall(input logic [DW-1:0] d);
        clk_en_n = 1; load_n = 0;
        sel_a_n = 0; sel_b = 1; sel_c_n = 0; wr_n = 0;
        addr = 8'he0; byte_en_n = 5'h00;
        tick(d);
        clk_en_n = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] a;
        logic [DW-1:0] dk [4];

        // R10: reset state
        repeat (3) @(negedge clk);
        chk_b("R10 dout_en in reset", dout_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_b("R10 dout_en after reset", dout_en, 1'b0);
        chk_v("R10 dout after reset", dout, '0);

        // Full write stream then full read stream (R4, R3, R11)
        for (int i = 0; i < 256; i++) begin
            ld_wr(8'(i), 5'h00, (i == 0) ? '0 : pat(i - 1, 1));
            chk_b("R4 bus off in write data cycle", dout_en, 1'b0);
        end
        for (int i = 0; i < 256; i++) begin
            ld_rd(8'(i), (i == 0) ? pat(255, 1) : '0);
            chk_b("R3 read drives bus", dout_en, 1'b1);
            chk_v("R11 sweep readback", dout, pat(i, 1));
        end

        // R11: write then immediate read of the same word
        for (int i = 0; i < 16; i++) begin
            ld_wr(8'(i), 5'h00, '0);
            ld_rd(8'(i), pat(i, 2));
            chk_v("R11 read right after write", dout, pat(i, 2));
        end

        // R5: every byte enable combination over a zeroed word
        for (int m = 0; m < 32; m++) begin
            logic [DW-1:0] e;
            a = 8'(8'h20 + m);
            ld_wr(a, 5'h00, '0);
            desel('0);
            ld_wr(a, 5'(m), '0);
            desel({DW{1'b1}});
            ld_rd(a, '0);
            for (int i = 0; i < 5; i++) e[i*8 +: 8] = m[i] ? 8'h00 : 8'hff;
            chk_v("R5 byte lane mask", dout, e);
        end

        // R7 / R8 / R6: bursts from each start offset in both orders
        for (int md = 0; md < 2; md++) begin
            desel('0);
            burst_ilv = md[0];
            for (int s = 0; s < 4; s++) begin
                a = {6'(6'h30 + md * 4 + s), 2'(s)};
                for (int k = 0; k < 4; k++) dk[k] = pat(k + 4 * s + 16 * md, 5);
                ld_wr(a, 5'h00, '0);
                for (int k = 1; k < 4; k++) adv(1'b1, ea(a, k, md[0]), 5'h00, dk[k-1]);
                desel(dk[3]);
                for (int k = 0; k < 4; k++) begin
                    ld_rd(ea(a, k, md[0]), '0);
                    chk_v(md[0] ? "R8 interleaved write beat placement"
                                : "R7 linear write beat placement", dout, dk[k]);
                end
                ld_rd(a, '0);
                chk_v("R6 burst read beat 0", dout, dk[0]);
                for (int k = 1; k < 5; k++) begin
                    adv(1'b0, ea(a, k, md[0]), 5'h1f, '0);
                    chk_v(md[0] ? "R8 interleaved read beat" : "R7 linear read beat",
                          dout, dk[k % 4]);
                    if (k == 1 && s == 0) begin
                        stall('0);
                        chk_v("R2 stall holds read data", dout, dk[1]);
                        chk_b("R2 stall holds dout_en", dout_en, 1'b1);
                    end
                end
            end
        end
        desel('0);
        burst_ilv = 1'b0;

        // R2: stall in a write data cycle, din at the stalled edge ignored
        ld_wr(8'h05, 5'h00, '0);
        stall(40'hdead_beef_00);
        chk_b("R2 stall keeps write data cycle off", dout_en, 1'b0);
        desel(pat(5, 9));
        ld_rd(8'h05, '0);
        chk_v("R2 write uses data at next enabled edge", dout, pat(5, 9));
        ld_rd(8'he0, '0);
        chk_v("R2 stalled load ignored", dout, pat(8'he0, 1));

        // R1: every partial select combination deselects
        for (int c = 0; c < 8; c++) begin
            if (c == 2) continue;
            issue(c[0], c[1], c[2], 1'b1, 8'h40, 5'h1f, '0);
            chk_b("R1 partial select read not driven", dout_en, 1'b0);
        end
        issue(1'b1, 1'b1, 1'b0, 1'b0, 8'h41, 5'h00, '0);
        desel(40'h12_3456_789a);
        ld_rd(8'h41, '0);
        chk_v("R1 partial select write ignored", dout, pat(8'h41, 1));

        // R9: deselect, then advance with all selects active stays deselected
        desel('0);
        chk_b("R9 deselected bus off", dout_en, 1'b0);
        clk_en_n = 0; load_n = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0; wr_n = 1;
        nw = 0;
        tick('0);
        chk_b("R9 advance after deselect stays off", dout_en, 1'b0);

        // R3: dummy read and asynchronous oe_n
        oe_n = 1'b1;
        ld_rd(8'h80, '0);
        chk_b("R3 dummy read off", dout_en, 1'b0);
        chk_v("R3 dummy read dout", dout, '0);
        oe_n = 1'b0;
        #1;
        chk_b("R3 oe_n low mid cycle drives", dout_en, 1'b1);
        chk_v("R3 oe_n low mid cycle data", dout, pat(8'h80, 1));
        oe_n = 1'b1;
        #1;
        chk_b("R3 oe_n high mid cycle releases", dout_en, 1'b0);
        oe_n = 1'b0;

        // R4: oe_n low does not enable a write data cycle
        ld_wr(8'h81, 5'h00, '0);
        chk_b("R4 write data cycle off with oe_n low", dout_en, 1'b0);
        ld_rd(8'h81, pat(1, 77));
        chk_v("R4 late write data stored", dout, pat(1, 77));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule